// File: doc/BRIEF.md
# Port Pattern-Match Interrupt Detector

This block watches a parallel input port and latches an interrupt-pending flag when a programmed combination of levels and transitions appears on it. Each bit of the port can be included or left out of the evaluation. Each included bit is either level-sensitive or edge-sensitive, and a polarity bit picks high/rising or low/falling. The included bits are combined either in OR fashion, where any satisfied bit fires, or in AND fashion, where every included bit must be satisfied in the same cycle. Before any of this, a data-path polarity register can invert individual input lines.

The inputs pass through a two-stage synchronizer. Edges are formed by comparing the synchronized sample with the one taken a cycle earlier. Software programs the configuration while the port is disabled and then enables it. Interrupts are steered with command codes that set or clear the enable flag, or clear the pending and in-service flags together. An interrupt request is raised while both enable and pending are set.

Top module: `pattern_irq_port`

## Requirements
- R1: After reset, int_en, int_pend, in_service, irq and cfg_err are 0. Mask, transition and polarity reset to 0, mode resets to disabled, and data-path polarity resets to all ones (no inversion).
- R2: For a bit with transition 0, polarity 1 selects a high level and polarity 0 a low level. In OR mode (mode code 2) any included bit that meets its condition sets int_pend, and bits with mask 0 are ignored. A level applied to port_in appears on int_pend after the third rising clock edge.
- R3: For a bit with transition 1, polarity 1 selects a rising edge and polarity 0 a falling edge. Only the transition sets int_pend. Holding the level steady does not, and neither does enabling the port.
- R4: In AND mode (mode code 1), int_pend is set only when every included bit meets its condition in the same cycle. A mask of all zeros never fires.
- R5: In AND mode with exactly one edge-sensitive included bit, its edge fires only if all included level bits are already satisfied in the cycle the edge is seen.
- R6: cfg_err is 1 while the mode is AND and more than one included bit is edge-sensitive. No event is taken while cfg_err is 1.
- R7: A data-path polarity bit of 0 inverts that input before matching, so a value of 0x7F inverts bit 7 only.
- R8: irq is 1 exactly when int_en and int_pend are both 1. Command code 1 sets int_en and code 2 clears it, and neither changes int_pend.
- R9: int_pend stays set after the condition goes away, until command code 3 clears it together with in_service. If an event arrives in the same cycle as the clear, the event wins.
- R10: irq_ack while irq is 1 sets in_service.
- R11: With port_en 0, no event is taken and configuration writes are accepted. Configuration writes made while port_en is 1 are ignored. The register addresses are: 0 mask, 1 transition, 2 polarity, 3 data-path polarity, and 4 mode (low two bits).
- R12: Mode codes 0 and 3 take no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Enables the detector; configuration is locked while 1 |
| port_in | input | WIDTH | Asynchronous input port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | WIDTH | Configuration write data |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 3 | Command: 1 set enable, 2 clear enable, 3 clear pending and in-service |
| irq_ack | input | 1 | Interrupt acknowledge, sets in-service while irq is 1 |
| irq | output | 1 | Interrupt request |
| int_en | output | 1 | Interrupt-enable flag |
| int_pend | output | 1 | Interrupt-pending flag |
| in_service | output | 1 | Interrupt-under-service flag |
| cfg_err | output | 1 | AND mode has more than one edge-sensitive included bit |

## Verification
The hardest situation to reach is the AND case in which the single edge bit sees its transition while the level bits are, or are not, already satisfied. Because the pending flag latches, each attempt must be observed in isolation. The stimulus therefore walks the level bit and the edge bit through separate steps, waiting out the synchronizer between steps: edge with level unmet, edge removed, level met alone, then edge with level met. Only the last step may raise the flag. The same-cycle race between an event and a clear command is produced by issuing the clear while a level condition is held true.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_AND = 2'b01,
    MODE_OR  = 2'b10,
    MODE_RSV = 2'b11
  } match_mode_e;

  localparam logic [2:0] CMD_SET_IE     = 3'd1;
  localparam logic [2:0] CMD_CLR_IE     = 3'd2;
  localparam logic [2:0] CMD_CLR_IP_IUS = 3'd3;

  localparam logic [2:0] ADDR_MASK  = 3'd0;
  localparam logic [2:0] ADDR_TRANS = 3'd1;
  localparam logic [2:0] ADDR_POL   = 3'd2;
  localparam logic [2:0] ADDR_DPP   = 3'd3;
  localparam logic [2:0] ADDR_MODE  = 3'd4;
endpackage

// File: rtl/pmi_sync.sv
module pmi_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[LAST];
endmodule

// File: rtl/pmi_cfg_regs.sv
module pmi_cfg_regs
  import pmi_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [WIDTH-1:0] cfg_wdata,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] trans_q,
  output logic [WIDTH-1:0] pol_q,
  output logic [WIDTH-1:0] dpp_q,
  output logic [1:0]       mode_q
);
  logic wr_ok;
  assign wr_ok = cfg_we && !port_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      trans_q <= '0;
      pol_q   <= '0;
      dpp_q   <= '1;
      mode_q  <= MODE_OFF;
    end else if (wr_ok) begin
      case (cfg_addr)
        ADDR_MASK:  mask_q  <= cfg_wdata;
        ADDR_TRANS: trans_q <= cfg_wdata;
        ADDR_POL:   pol_q   <= cfg_wdata;
        ADDR_DPP:   dpp_q   <= cfg_wdata;
        ADDR_MODE:  mode_q  <= cfg_wdata[1:0];
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pmi_match.sv
module pmi_match
  import pmi_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic [WIDTH-1:0] din_sync,
  input  logic [WIDTH-1:0] mask,
  input  logic [WIDTH-1:0] trans,
  input  logic [WIDTH-1:0] pol,
  input  logic [WIDTH-1:0] dpp,
  input  logic [1:0]       mode,
  output logic             hit,
  output logic             cfg_err
);
  logic [WIDTH-1:0] cur, prv_q, ok_vec;
  logic             prv_ok_q, raw_match;

  function automatic logic [WIDTH-1:0] apply_dpp(input logic [WIDTH-1:0] d,
                                                 input logic [WIDTH-1:0] p);
    return ~(d ^ p);
  endfunction

  function automatic logic [WIDTH-1:0] bit_conditions(
      input logic [WIDTH-1:0] c, input logic [WIDTH-1:0] p,
      input logic edge_ok, input logic [WIDTH-1:0] t, input logic [WIDTH-1:0] s);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      if (t[i]) r[i] = edge_ok && (s[i] ? (c[i] && !p[i]) : (!c[i] && p[i]));
      else      r[i] = s[i] ? c[i] : !c[i];
    end
    return r;
  endfunction

  function automatic logic all_match(input logic [WIDTH-1:0] ok,
                                     input logic [WIDTH-1:0] m);
    return (|m) && (&(ok | ~m));
  endfunction

  function automatic logic any_match(input logic [WIDTH-1:0] ok,
                                     input logic [WIDTH-1:0] m);
    return |(ok & m);
  endfunction

  assign cur = apply_dpp(din_sync, dpp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prv_q    <= '0;
      prv_ok_q <= 1'b0;
    end else begin
      prv_q    <= cur;
      prv_ok_q <= port_en;
    end
  end

  assign ok_vec  = bit_conditions(cur, prv_q, prv_ok_q, trans, pol);
  assign cfg_err = (mode == MODE_AND) && ($countones(trans & mask) > 1);

  always_comb begin
    case (mode)
      MODE_AND: raw_match = all_match(ok_vec, mask);
      MODE_OR:  raw_match = any_match(ok_vec, mask);
      default:  raw_match = 1'b0;
    endcase
  end

  assign hit = port_en && prv_ok_q && !cfg_err && raw_match;
endmodule

// File: rtl/pmi_intr_ctl.sv
module pmi_intr_ctl
  import pmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       cmd_we,
  input  logic [2:0] cmd_code,
  input  logic       irq_ack,
  output logic       int_en,
  output logic       int_pend,
  output logic       in_service,
  output logic       irq
);
  logic do_set_ie, do_clr_ie, do_clr_ip;

  assign do_set_ie = cmd_we && (cmd_code == CMD_SET_IE);
  assign do_clr_ie = cmd_we && (cmd_code == CMD_CLR_IE);
  assign do_clr_ip = cmd_we && (cmd_code == CMD_CLR_IP_IUS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en     <= 1'b0;
      int_pend   <= 1'b0;
      in_service <= 1'b0;
    end else begin
      if (do_set_ie)      int_en <= 1'b1;
      else if (do_clr_ie) int_en <= 1'b0;

      if (hit)            int_pend <= 1'b1;
      else if (do_clr_ip) int_pend <= 1'b0;

      if (do_clr_ip)            in_service <= 1'b0;
      else if (irq_ack && irq)  in_service <= 1'b1;
    end
  end

  assign irq = int_en && int_pend;
endmodule

// File: rtl/pattern_irq_port.sv
module pattern_irq_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic [WIDTH-1:0] port_in,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [WIDTH-1:0] cfg_wdata,
  input  logic             cmd_we,
  input  logic [2:0]       cmd_code,
  input  logic             irq_ack,
  output logic             irq,
  output logic             int_en,
  output logic             int_pend,
  output logic             in_service,
  output logic             cfg_err
);
  logic [WIDTH-1:0] din_sync, mask_q, trans_q, pol_q, dpp_q;
  logic [1:0]       mode_q;
  logic             evt_hit;

  pmi_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(port_in), .dout(din_sync)
  );

  pmi_cfg_regs #(.WIDTH(WIDTH)) cfg_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mask_q(mask_q),
    .trans_q(trans_q), .pol_q(pol_q), .dpp_q(dpp_q), .mode_q(mode_q)
  );

  pmi_match #(.WIDTH(WIDTH)) match_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .din_sync(din_sync),
    .mask(mask_q), .trans(trans_q), .pol(pol_q), .dpp(dpp_q),
    .mode(mode_q), .hit(evt_hit), .cfg_err(cfg_err)
  );

  pmi_intr_ctl intr_i (
    .clk(clk), .rst_n(rst_n), .hit(evt_hit), .cmd_we(cmd_we),
    .cmd_code(cmd_code), .irq_ack(irq_ack), .int_en(int_en),
    .int_pend(int_pend), .in_service(in_service), .irq(irq)
  );
endmodule

// File: rtl/pmi_checker.sv
module pmi_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       cmd_we,
  input logic [2:0] cmd_code,
  input logic       irq_ack,
  input logic       irq,
  input logic       int_en,
  input logic       int_pend,
  input logic       in_service,
  input logic       cfg_err,
  input logic       evt_hit,
  input logic [1:0] mode_q
);
  assert_pend_fall_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_pend) |-> $past(cmd_we && cmd_code == 3'd3));

  assert_pend_rise_evt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_pend) |-> $past(evt_hit));

  assert_no_evt_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !evt_hit);

  assert_no_evt_cfgerr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !evt_hit);

  assert_no_evt_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00 || mode_q == 2'b11) |-> !evt_hit);

  assert_ius_rise_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_service) |-> $past(irq_ack && irq));

  assert_en_rise_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_en) |-> $past(cmd_we && cmd_code == 3'd1));

  assert_en_fall_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_en) |-> $past(cmd_we && cmd_code == 3'd2));
endmodule

bind pattern_irq_port pmi_checker chk_i (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .cmd_we(cmd_we),
  .cmd_code(cmd_code), .irq_ack(irq_ack), .irq(irq), .int_en(int_en),
  .int_pend(int_pend), .in_service(in_service), .cfg_err(cfg_err),
  .evt_hit(evt_hit), .mode_q(mode_q)
);

// File: tb/pattern_irq_port_tb.sv
module pattern_irq_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 13;

  // {mode[2], mask[8], pol[8], dpp[8], input[8], expected pend[1]}
  localparam logic [34:0] VEC [NVEC] = '{
    {2'd2, 8'h01, 8'h01, 8'hFF, 8'h01, 1'b1},  // R2 high level
    {2'd2, 8'h01, 8'h01, 8'hFF, 8'hFE, 1'b0},  // R2 level not met
    {2'd2, 8'h0F, 8'h00, 8'hFF, 8'hFF, 1'b0},  // R2 low wanted, all high
    {2'd2, 8'h0F, 8'h00, 8'hFF, 8'hF7, 1'b1},  // R2 one low bit
    {2'd1, 8'h0F, 8'h05, 8'hFF, 8'h05, 1'b1},  // R4 all match
    {2'd1, 8'h0F, 8'h05, 8'hFF, 8'h07, 1'b0},  // R4 one mismatch
    {2'd1, 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0},  // R4 empty mask
    {2'd2, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0},  // R2 masked bits ignored
    {2'd1, 8'hF0, 8'hF0, 8'hFF, 8'hF0, 1'b1},  // R4 upper nibble
    {2'd2, 8'h80, 8'h80, 8'h7F, 8'h00, 1'b1},  // R7 bit 7 inverted
    {2'd2, 8'h80, 8'h80, 8'h7F, 8'h80, 1'b0},  // R7 bit 7 inverted
    {2'd0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0},  // R12 disabled
    {2'd3, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0}   // R12 reserved
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 1'b0, cfg_we = 1'b0, cmd_we = 1'b0, irq_ack = 1'b0;
  logic [W-1:0] port_in = '0, cfg_wdata = '0;
  logic [2:0] cfg_addr = '0, cmd_code = '0;
  logic irq, int_en, int_pend, in_service, cfg_err;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_irq_port #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .port_in(port_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cmd_we(cmd_we), .cmd_code(cmd_code), .irq_ack(irq_ack), .irq(irq),
    .int_en(int_en), .int_pend(int_pend), .in_service(in_service),
    .cfg_err(cfg_err)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] c);
    cmd_we = 1'b1; cmd_code = c;
    tick(1);
    cmd_we = 1'b0; cmd_code = '0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [7:0] mk, input logic [7:0] tr,
                       input logic [7:0] pl, input logic [7:0] dp, input logic [7:0] din);
    port_en = 1'b0;
    tick(1);
    wcfg(3'd0, mk); wcfg(3'd1, tr); wcfg(3'd2, pl); wcfg(3'd3, dp);
    wcfg(3'd4, {6'd0, m});
    port_in = din;
    cmd(3'd3);
    tick(3);
  endtask

  initial begin
    @(negedge clk);
    tick(3);
    // R1 reset state (cycles held in reset)
    check("R1 int_en", {7'd0, int_en}, 8'h00);
    check("R1 int_pend", {7'd0, int_pend}, 8'h00);
    check("R1 in_service", {7'd0, in_service}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 cfg_err", {7'd0, cfg_err}, 8'h00);
    rst_n = 1'b1;
    tick(1);
    // R1: reset config is mode off, so a driven input takes no event
    port_in = 8'hFF; port_en = 1'b1;
    tick(5);
    check("R1 idle after reset", {7'd0, int_pend}, 8'h00);

    // table walk: level patterns
    for (int v = 0; v < NVEC; v++) begin
      setup(VEC[v][34:33], VEC[v][32:25], 8'h00, VEC[v][24:17], VEC[v][16:9], VEC[v][8:1]);
      port_en = 1'b1;
      tick(4);
      check($sformatf("R2/R4/R7/R12 vector %0d", v), {7'd0, int_pend}, {7'd0, VEC[v][0]});
    end

    // R3 rising edge on bit 2
    setup(2'd2, 8'h04, 8'h04, 8'h04, 8'hFF, 8'h00);
    port_en = 1'b1;
    tick(4);
    check("R3 no event on enable", {7'd0, int_pend}, 8'h00);
    port_in = 8'h04;
    tick(3);
    check("R3 rising edge", {7'd0, int_pend}, 8'h01);
    cmd(3'd3);
    tick(2);
    check("R3 steady high no event", {7'd0, int_pend}, 8'h00);
    port_in = 8'h00;
    tick(3);
    check("R3 falling ignored", {7'd0, int_pend}, 8'h00);
    // R3 falling edge selected
    setup(2'd2, 8'h04, 8'h04, 8'h00, 8'hFF, 8'h04);
    port_en = 1'b1;
    tick(4);
    check("R3 steady high, falling sel", {7'd0, int_pend}, 8'h00);
    port_in = 8'h00;
    tick(3);
    check("R3 falling edge", {7'd0, int_pend}, 8'h01);

    // R5 AND: bit0 rising edge, bit1 high level
    setup(2'd1, 8'h03, 8'h01, 8'h03, 8'hFF, 8'h00);
    check("R5 single edge no cfg_err", {7'd0, cfg_err}, 8'h00);
    port_en = 1'b1;
    tick(4);
    port_in = 8'h01;
    tick(3);
    check("R5 edge without level", {7'd0, int_pend}, 8'h00);
    port_in = 8'h00;
    tick(3);
    port_in = 8'h02;
    tick(3);
    check("R5 level without edge", {7'd0, int_pend}, 8'h00);
    port_in = 8'h03;
    tick(3);
    check("R5 edge with level", {7'd0, int_pend}, 8'h01);

    // R6 two edge bits in AND mode
    setup(2'd1, 8'h03, 8'h03, 8'h03, 8'hFF, 8'h00);
    check("R6 cfg_err set", {7'd0, cfg_err}, 8'h01);
    port_en = 1'b1;
    tick(4);
    port_in = 8'h03;
    tick(3);
    check("R6 no event on error", {7'd0, int_pend}, 8'h00);
    setup(2'd2, 8'h03, 8'h03, 8'h03, 8'hFF, 8'h00);
    check("R6 cfg_err clear in OR", {7'd0, cfg_err}, 8'h00);

    // R8/R9/R10 command protocol
    setup(2'd2, 8'h01, 8'h00, 8'h01, 8'hFF, 8'h01);
    port_en = 1'b1;
    tick(4);
    check("R8 pend without enable", {6'd0, int_pend, irq}, 8'h02);
    cmd(3'd3);
    check("R9 event wins over clear", {7'd0, int_pend}, 8'h01);
    port_in = 8'h00;
    tick(3);
    check("R9 pend latched", {7'd0, int_pend}, 8'h01);
    cmd(3'd1);
    check("R8 set enable", {5'd0, int_en, int_pend, irq}, 8'h07);
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    check("R10 in_service set", {7'd0, in_service}, 8'h01);
    cmd(3'd2);
    check("R8 clear enable", {5'd0, int_en, int_pend, irq}, 8'h02);
    cmd(3'd3);
    check("R9 clear pend", {7'd0, int_pend}, 8'h00);
    check("R10 clear in_service", {7'd0, in_service}, 8'h00);

    // R11 config locked while enabled
    wcfg(3'd2, 8'h00);
    tick(3);
    check("R11 write while enabled ignored", {7'd0, int_pend}, 8'h00);
    port_en = 1'b0;
    port_in = 8'h01;
    tick(5);
    check("R11 no event while disabled", {7'd0, int_pend}, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule